// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Nibble Codec

This block guards a 4-bit data nibble with 4 check bits so that the stored 8-bit word survives a single flipped bit and reports, without miscorrecting, any two flipped bits. The encoder half turns a nibble into an 8-bit codeword in the same cycle. The decoder half takes an 8-bit word read back from storage, forms a 4-bit syndrome, and returns the repaired nibble with two status flags.

The check matrix gives every codeword bit a column that is nonzero, unique and of odd weight. Each check bit owns one unit column; each data bit owns one of the four weight-3 columns. Because all columns have odd weight, one flipped bit always yields an odd-weight syndrome and two flipped bits always yield a nonzero even-weight one, so the syndrome's weight parity alone separates a repairable word from an unrepairable one. The decoder outputs pass through an optional register chosen by a parameter.

Top module: `secded84_codec`

## Requirements
- R1: `code_out[3:0]` equals `data_in`; check bit `code_out[4+i]` is the XOR of the three data bits other than bit `i` (data bit `j` has check column all-ones except bit `j`; check bit `i` has the unit column with bit `i` set).
- R2: The encoder is combinational: `code_out` follows `data_in` within the same cycle.
- R3: Syndrome bit `i` is `code_in[4+i]` XOR the data bits of `code_in` other than bit `i`; a zero syndrome gives `data_out = code_in[3:0]` with both flags low.
- R4: A weight-3 syndrome whose only zero is at bit `j` flips data bit `j` on `data_out` and raises `err_corrected` only.
- R5: A weight-1 syndrome marks a check-bit error: `data_out = code_in[3:0]` and `err_corrected` is raised alone.
- R6: A nonzero even-weight syndrome (any two flipped bits) raises `err_uncorrectable` only, and `data_out = code_in[3:0]` unaltered.
- R7: `err_corrected` and `err_uncorrectable` are never high together.
- R8: With `OUT_REG = 1` (default) the decoder outputs take the result for `code_in` at the rising edge after it is applied and hold until the next edge; with `OUT_REG = 0` they are combinational.
- R9: While `rst_n` is low the registered decoder outputs are all zero, taking effect without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional decoder output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 4 | Nibble to encode |
| code_out | output | 8 | Codeword: data in bits 3:0, check bits in 7:4 |
| code_in | input | 8 | Word read back from storage, same layout |
| data_out | output | 4 | Decoded, corrected nibble |
| err_corrected | output | 1 | Single-bit error was found and handled |
| err_uncorrectable | output | 1 | Double-bit error was detected |

## Verification
The encoder result is due in the same cycle as `data_in`, so the bench samples `code_out` one nanosecond after driving it. Decoder inputs are driven on a falling edge and the registered result is read on the next falling edge, one rising edge later; one directed case also reads the outputs just before that edge to confirm they still show the previous word. The reset checks sample a nanosecond after `rst_n` falls, with no clock edge between.

// File: rtl/secded_pkg.sv
package secded_pkg;

   localparam int SEC_DATA_W = 4;
   localparam int SEC_CHK_W  = 4;
   localparam int SEC_CODE_W = SEC_DATA_W + SEC_CHK_W;

   typedef enum logic [1:0] {
      DEC_CLEAN = 2'd0,
      DEC_FIXED = 2'd1,
      DEC_FATAL = 2'd2
   } dec_status_e;

   // Check-matrix column of data bit j: weight 3, zero only at bit j.
   function automatic logic [SEC_CHK_W-1:0] data_column(input int j);
      logic [SEC_CHK_W-1:0] col;
      col = '1;
      col[j] = 1'b0;
      return col;
   endfunction

   // Data bits that feed check row i (same shape, by symmetry).
   function automatic logic [SEC_DATA_W-1:0] row_data_mask(input int i);
      logic [SEC_DATA_W-1:0] m;
      for (int j = 0; j < SEC_DATA_W; j++) begin
         m[j] = data_column(j)[i];
      end
      return m;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
   import secded_pkg::*;
#(
   parameter int DATA_W = SEC_DATA_W,
   parameter int CHK_W  = SEC_CHK_W
) (
   input  logic [DATA_W-1:0]       dat,
   output logic [DATA_W+CHK_W-1:0] word
);
   logic [CHK_W-1:0] chk;

   for (genvar i = 0; i < CHK_W; i++) begin : g_row
      assign chk[i] = ^(dat & row_data_mask(i));
   end

   assign word = {chk, dat};
endmodule

// File: rtl/secded_syn.sv
module secded_syn
   import secded_pkg::*;
#(
   parameter int DATA_W = SEC_DATA_W,
   parameter int CHK_W  = SEC_CHK_W
) (
   input  logic [DATA_W+CHK_W-1:0] word,
   output logic [CHK_W-1:0]        syn
);
   logic [DATA_W-1:0] dat;
   assign dat = word[DATA_W-1:0];

   for (genvar i = 0; i < CHK_W; i++) begin : g_row
      assign syn[i] = word[DATA_W+i] ^ (^(dat & row_data_mask(i)));
   end
endmodule

// File: rtl/secded_fix.sv
module secded_fix
   import secded_pkg::*;
#(
   parameter int DATA_W = SEC_DATA_W,
   parameter int CHK_W  = SEC_CHK_W
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [CHK_W-1:0]  syn,
   output logic [DATA_W-1:0] fixed,
   output dec_status_e       status
);
   localparam int WGT_W = $clog2(CHK_W + 1);

   logic [DATA_W-1:0] flip;
   logic [WGT_W-1:0]  weight;

   for (genvar j = 0; j < DATA_W; j++) begin : g_hit
      assign flip[j] = (syn == data_column(j));
   end

   always_comb begin
      weight = WGT_W'($countones(syn));
      if (syn == '0) begin
         status = DEC_CLEAN;
      end else if (weight[0]) begin
         status = DEC_FIXED;
      end else begin
         status = DEC_FATAL;
      end
   end

   // flip is all-zero unless the syndrome matches a data column
   assign fixed = raw ^ flip;
endmodule

// File: rtl/secded84_codec.sv
module secded84_codec
   import secded_pkg::*;
#(
   parameter int DATA_W  = 4,
   parameter int CHK_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DATA_W-1:0]        data_in,
   output logic [DATA_W+CHK_W-1:0]  code_out,
   input  logic [DATA_W+CHK_W-1:0]  code_in,
   output logic [DATA_W-1:0]        data_out,
   output logic                     err_corrected,
   output logic                     err_uncorrectable
);
   localparam int CODE_W = DATA_W + CHK_W;

   if (DATA_W != SEC_DATA_W) begin : g_bad_data_w
      $error("secded84_codec: DATA_W must be %0d", SEC_DATA_W);
   end
   if (CHK_W != SEC_CHK_W) begin : g_bad_chk_w
      $error("secded84_codec: CHK_W must be %0d", SEC_CHK_W);
   end
   if (CODE_W != SEC_CODE_W) begin : g_bad_code_w
      $error("secded84_codec: codeword width mismatch");
   end

   logic [CHK_W-1:0]  syndrome;
   logic [DATA_W-1:0] fixed_dat;
   dec_status_e       status;
   logic              nxt_corr;
   logic              nxt_unc;

   secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .dat  (data_in),
      .word (code_out)
   );

   secded_syn #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_syn (
      .word (code_in),
      .syn  (syndrome)
   );

   secded_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
      .raw    (code_in[DATA_W-1:0]),
      .syn    (syndrome),
      .fixed  (fixed_dat),
      .status (status)
   );

   assign nxt_corr = (status == DEC_FIXED);
   assign nxt_unc  = (status == DEC_FATAL);

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_out          <= '0;
            err_corrected     <= 1'b0;
            err_uncorrectable <= 1'b0;
         end else begin
            data_out          <= fixed_dat;
            err_corrected     <= nxt_corr;
            err_uncorrectable <= nxt_unc;
         end
      end
   end else begin : g_comb
      assign data_out          = fixed_dat;
      assign err_corrected     = nxt_corr;
      assign err_uncorrectable = nxt_unc;
   end
endmodule

// File: rtl/secded_chk.sv
module secded_chk #(
   parameter bit REGISTERED = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] data_in,
   input logic [7:0] code_out,
   input logic [7:0] code_in,
   input logic [3:0] syn,
   input logic [3:0] data_out,
   input logic       err_corrected,
   input logic       err_uncorrectable
);
   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   // R7
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_corrected && err_uncorrectable));

   if (REGISTERED) begin : g_seq
      // R3
      clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         live && (syn == 4'd0) |=> !err_corrected && !err_uncorrectable
                                   && data_out == $past(code_in[3:0]));
      // R4
      data_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
         live && ($countones(syn) == 3) |=> err_corrected && !err_uncorrectable
            && ($countones(data_out ^ $past(code_in[3:0])) == 1));
      // R5
      check_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         live && ($countones(syn) == 1) |=> err_corrected
            && data_out == $past(code_in[3:0]));
      // R6
      double_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         live && (syn != 4'd0) && !(^syn) |=> err_uncorrectable && !err_corrected
            && data_out == $past(code_in[3:0]));
      // R1
      loopback_chk: assert property (@(posedge clk) disable iff (!rst_n)
         live && (code_in == code_out) |=> !err_corrected && !err_uncorrectable
            && data_out == $past(data_in));
   end
endmodule

bind secded84_codec secded_chk #(.REGISTERED(OUT_REG)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .data_in           (data_in),
   .code_out          (code_out),
   .code_in           (code_in),
   .syn               (syndrome),
   .data_out          (data_out),
   .err_corrected     (err_corrected),
   .err_uncorrectable (err_uncorrectable)
);

// File: tb/test_secded84_codec.sv
`timescale 1ns/1ps
module test_secded84_codec;
   localparam int HALF_NS = 10;
   localparam int WD_NS   = 200000 * 2 * HALF_NS;

   // Expected codeword per nibble, index = data value (R1).
   localparam logic [7:0] CODE_TBL [16] = '{
      8'h00, 8'hE1, 8'hD2, 8'h33, 8'hB4, 8'h55, 8'h66, 8'h87,
      8'h78, 8'h99, 8'hAA, 8'h4B, 8'hCC, 8'h2D, 8'h1E, 8'hFF
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic [3:0] data_in = '0;
   logic [7:0] code_in = '0;
   logic [7:0] code_out;
   logic [3:0] data_out;
   logic       err_corrected;
   logic       err_uncorrectable;

   int checks = 0;
   int fails  = 0;

   always #HALF_NS clk = ~clk;

   secded84_codec i_secded84_codec (
      .clk               (clk),
      .rst_n             (rst_n),
      .data_in           (data_in),
      .code_out          (code_out),
      .code_in           (code_in),
      .data_out          (data_out),
      .err_corrected     (err_corrected),
      .err_uncorrectable (err_uncorrectable)
   );

   task automatic expect_dec(input string req, input logic [3:0] d,
                             input logic c, input logic u);
      checks++;
      if (data_out !== d || err_corrected !== c || err_uncorrectable !== u
          || (err_corrected && err_uncorrectable)) begin
         fails++;
         $display("FAIL %s code_in=%h actual data=%h corr=%b unc=%b expected data=%h corr=%b unc=%b",
                  req, code_in, data_out, err_corrected, err_uncorrectable, d, c, u);
      end
   endtask

   task automatic decode(input string req, input logic [7:0] w,
                         input logic [3:0] d, input logic c, input logic u);
      @(negedge clk);
      code_in = w;
      @(negedge clk);
      expect_dec(req, d, c, u);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #WD_NS;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      // R9: asynchronous reset clears the outputs
      #1 rst_n = 1'b0;
      #4;
      expect_dec("R9", 4'h0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1, R2: encoder over all nibbles, same cycle
      for (int v = 0; v < 16; v++) begin
         data_in = 4'(v);
         #1;
         checks++;
         if (code_out !== CODE_TBL[v]) begin
            fails++;
            $display("FAIL R1/R2 data_in=%h actual=%h expected=%h", v, code_out, CODE_TBL[v]);
         end
      end

      // Table walk: clean, every single flip, every double flip
      for (int v = 0; v < 16; v++) begin
         decode("R3", CODE_TBL[v], 4'(v), 1'b0, 1'b0);
         for (int k = 0; k < 8; k++) begin
            if (k < 4) decode("R4", CODE_TBL[v] ^ (8'd1 << k), 4'(v), 1'b1, 1'b0);
            else       decode("R5", CODE_TBL[v] ^ (8'd1 << k), 4'(v), 1'b1, 1'b0);
         end
         for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
               logic [7:0] w;
               w = CODE_TBL[v] ^ (8'd1 << a) ^ (8'd1 << b);
               decode("R6", w, w[3:0], 1'b0, 1'b1);
            end
         end
      end

      // R8: result appears only after the next rising edge
      decode("R8", CODE_TBL[5], 4'h5, 1'b0, 1'b0);
      @(negedge clk);
      code_in = CODE_TBL[5] ^ 8'h02;
      #1;
      expect_dec("R8", 4'h5, 1'b0, 1'b0);
      @(negedge clk);
      expect_dec("R8", 4'h5, 1'b1, 1'b0);

      // R7 / R6 corner: data bit and its own check bit both flipped
      decode("R7", CODE_TBL[9] ^ 8'h11, 4'h8, 1'b0, 1'b1);

      // R9: mid-run reset drops flags without a clock edge
      decode("R9", CODE_TBL[3] ^ 8'h80, 4'h3, 1'b1, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      expect_dec("R9", 4'h0, 1'b0, 1'b0);
      @(negedge clk);
      expect_dec("R9", 4'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      decode("R3", CODE_TBL[12], 4'hC, 1'b0, 1'b0);

      finish_run();
   end
endmodule